// File: doc/BRIEF.md
# Privileged Performance Monitor Register File

This block holds the configuration and count state of a set of event counters used for performance monitoring. Software reaches it through one indexed access port with two address spaces, a configuration space and a data space, each with 256 slots. Every access carries the privilege level of the requester (0 is the most privileged, 3 the least) and a secure-read control bit. The block decides whether the access is legal, performs it, and returns read data or a fault pulse one cycle later.

A contiguous group of counter pairs starts at slot 4 in both spaces. Each pair has a configuration word that picks one event line from an event input bus and a mask of the privilege levels at which counting is allowed. Each pair also has a data word holding a `CNT_W`-bit counter. Configuration slot 0 holds a sticky overflow status vector. Every other slot is unimplemented. When any status bit is set, a single overflow output is raised, and the interrupt logic outside the block can use it.

The privilege level input `cur_priv` is the level of the code running now. It qualifies both the access on the port and the counting in the same cycle.

Top module: `pmu_regfile`

## Requirements
- R1: A read of an unimplemented slot returns zero with `rd_valid` high. In the configuration space, the unimplemented slots are 1 to 3 and every slot above `3+NUM_PAIRS`. In the data space, they are slots 0 to 3 and every slot above `3+NUM_PAIRS`.
- R2: A write to an unimplemented slot changes no state. Every implemented slot reads back the same value afterwards.
- R3: At a privilege level other than 0, any write and any configuration-space read raise `priv_fault` for one cycle, whatever the slot index. No data is returned (`rd_valid` low) and no state changes. At level 0 no access faults.
- R4: A data-space read at a nonzero level is legal. If `secure_rd` is 1, it returns zero. Otherwise it returns the counter value. At level 0, `secure_rd` has no effect.
- R5: Configuration slot 4+k belongs to counter k. Bits [3:0] of that word are the level mask, where bit n enables counting at level n. Bits [15:8] are the event select. All other bits read as zero.
- R6: A counter adds one in each cycle in which its selected event line is high and the mask bit for `cur_priv` is set. An event select of `NUM_EVT` or more never counts.
- R7: A data read returns the counter zero-extended to 64 bits. A data write loads the low `CNT_W` bits of the write data.
- R8: When a counter steps from all ones to zero, bit 4+k of configuration slot 0 becomes 1 and `ovf_irq` goes high in the cycle after that step.
- R9: Status bits are sticky. A level-0 write to configuration slot 0 loads bits [3+NUM_PAIRS:4] from the write data, so writing 0 clears them. If an overflow happens in the same cycle as that write, the overflow bit is set. `ovf_irq` is high exactly when some status bit is set.
- R10: When a data write and a count event hit the same counter in the same cycle, the written value is stored and the event is lost.
- R11: `rd_valid`, `rd_data` and `priv_fault` are registered. They answer the request accepted at the previous clock edge and are low or zero otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_space | input | 1 | 0 = configuration space, 1 = data space |
| acc_idx | input | 8 | Slot index |
| acc_wdata | input | 64 | Write data |
| cur_priv | input | 2 | Current privilege level (0 most privileged) |
| secure_rd | input | 1 | Masks data reads made at a nonzero level |
| evt_in | input | NUM_EVT | Event lines, one per selectable event |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| priv_fault | output | 1 | Privileged-operation fault pulse |
| ovf_irq | output | 1 | High while any overflow status bit is set |

## Verification
Counting is driven with the selected event line alone at an enabled level, with the same line at a masked level, and with every line except the selected one high. These three patterns separate errors in the level mask from errors in event selection. A fourth case selects an event beyond the bus width and checks that such a select never counts. Wraparound is approached from a preloaded near-full value, so a single step decides whether the status bit and `ovf_irq` appear on the correct edge. A write and an event arriving together tell whether the write or the count wins. Fault and secure-read cases are repeated at several levels and slot indices, including unimplemented slots, to show that the privilege check is made before the slot is decoded.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int XLEN      = 64;
    localparam int SLOT_W    = 8;
    localparam int PRIV_W    = 2;
    localparam int FIRST_CTR = 4;
    localparam int STS_SLOT  = 0;
    localparam int MASK_LSB  = 0;
    localparam int MASK_W    = 4;
    localparam int SEL_LSB   = 8;
    localparam int SEL_W     = 8;

    typedef enum logic {
        SPACE_CFG = 1'b0,
        SPACE_DAT = 1'b1
    } space_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        space_e            space;
        logic [SLOT_W-1:0] idx;
        logic [PRIV_W-1:0] priv;
        logic              secure;
    } acc_req_t;

    typedef struct packed {
        logic fault;
        logic rd_go;
        logic rd_zero;
        logic rd_sts;
        logic cfg_wr;
        logic dat_wr;
        logic sts_wr;
    } acc_dec_t;

    typedef struct packed {
        logic [MASK_W-1:0] lvl_mask;
        logic [SEL_W-1:0]  evt_sel;
    } ctr_cfg_t;

    function automatic ctr_cfg_t cfg_unpack(input logic [XLEN-1:0] w);
        ctr_cfg_t c;
        c.lvl_mask = w[MASK_LSB +: MASK_W];
        c.evt_sel  = w[SEL_LSB +: SEL_W];
        return c;
    endfunction

    function automatic logic [XLEN-1:0] cfg_pack(input ctr_cfg_t c);
        logic [XLEN-1:0] w;
        w = '0;
        w[MASK_LSB +: MASK_W] = c.lvl_mask;
        w[SEL_LSB +: SEL_W]   = c.evt_sel;
        return w;
    endfunction

endpackage

// File: rtl/pmu_access_ctrl.sv
module pmu_access_ctrl
    import pmu_pkg::*;
#(
    parameter int NUM_PAIRS = 4
) (
    input  acc_req_t             req,
    output acc_dec_t             dec,
    output logic [NUM_PAIRS-1:0] ctr_hit
);
    localparam int LAST_CTR = FIRST_CTR + NUM_PAIRS - 1;

    logic in_ctr;
    logic priv0;
    logic illegal;
    logic is_sts;
    logic masked;

    always_comb begin
        in_ctr  = (int'(req.idx) >= FIRST_CTR) && (int'(req.idx) <= LAST_CTR);
        priv0   = (req.priv == '0);
        // privilege check precedes any slot decode
        illegal = req.valid && !priv0 && (req.write || req.space == SPACE_CFG);
        is_sts  = (req.space == SPACE_CFG) && (int'(req.idx) == STS_SLOT);
        masked  = (req.space == SPACE_DAT) && !priv0 && req.secure;

        dec.fault   = illegal;
        dec.rd_go   = req.valid && !req.write && !illegal;
        dec.rd_sts  = is_sts;
        dec.rd_zero = !(in_ctr || is_sts) || masked;
        dec.cfg_wr  = req.valid && req.write && priv0 && in_ctr
                      && (req.space == SPACE_CFG);
        dec.dat_wr  = req.valid && req.write && priv0 && in_ctr
                      && (req.space == SPACE_DAT);
        dec.sts_wr  = req.valid && req.write && priv0 && is_sts;
    end

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_hit
        assign ctr_hit[k] = (int'(req.idx) == FIRST_CTR + k);
    end

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
    import pmu_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic               dat_we,
    input  ctr_cfg_t           cfg_wdata,
    input  logic [CNT_W-1:0]   cnt_wdata,
    input  logic [PRIV_W-1:0]  priv_lvl,
    input  logic [NUM_EVT-1:0] evt_in,
    output ctr_cfg_t           cfg_q,
    output logic [CNT_W-1:0]   cnt_q,
    output logic               wrap
);
    logic evt_hit;
    logic count_en;

    always_comb begin
        evt_hit = 1'b0;
        for (int e = 0; e < NUM_EVT; e++) begin
            if (int'(cfg_q.evt_sel) == e) evt_hit = evt_in[e];
        end
        count_en = evt_hit && cfg_q.lvl_mask[priv_lvl];
        wrap     = count_en && !dat_we && (&cnt_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (dat_we) begin
            cnt_q <= cnt_wdata;
        end else if (count_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pmu_ovf_status.sv
module pmu_ovf_status #(
    parameter int NUM_PAIRS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [NUM_PAIRS-1:0] wr_bits,
    input  logic [NUM_PAIRS-1:0] set_bits,
    output logic [NUM_PAIRS-1:0] sts_q,
    output logic                 any_set
);
    logic [NUM_PAIRS-1:0] base;

    always_comb begin
        base = wr_en ? wr_bits : sts_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
        end else begin
            sts_q <= base | set_bits;
        end
    end

    assign any_set = |sts_q;

endmodule

// File: rtl/pmu_regfile.sv
module pmu_regfile
    import pmu_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int CNT_W     = 16,
    parameter int NUM_EVT   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic               acc_space,
    input  logic [7:0]         acc_idx,
    input  logic [63:0]        acc_wdata,
    input  logic [1:0]         cur_priv,
    input  logic               secure_rd,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               rd_valid,
    output logic [63:0]        rd_data,
    output logic               priv_fault,
    output logic               ovf_irq
);
    acc_req_t             req;
    acc_dec_t             dec;
    logic [NUM_PAIRS-1:0] ctr_hit;
    ctr_cfg_t             cfg_q [NUM_PAIRS];
    logic [CNT_W-1:0]     cnt_q [NUM_PAIRS];
    logic [NUM_PAIRS-1:0] wrap_vec;
    logic [NUM_PAIRS-1:0] sts_q;
    logic [XLEN-1:0]      cfg_mux;
    logic [XLEN-1:0]      dat_mux;
    logic [XLEN-1:0]      sts_word;
    logic [XLEN-1:0]      rd_next;
    ctr_cfg_t             cfg_wr_val;
    logic                 unused_wdata_bits;

    assign unused_wdata_bits = ^acc_wdata;

    always_comb begin
        req.valid  = acc_valid;
        req.write  = acc_write;
        req.space  = space_e'(acc_space);
        req.idx    = acc_idx;
        req.priv   = cur_priv;
        req.secure = secure_rd;
        cfg_wr_val = cfg_unpack(acc_wdata);
    end

    pmu_access_ctrl #(.NUM_PAIRS(NUM_PAIRS)) u_acc (
        .req     (req),
        .dec     (dec),
        .ctr_hit (ctr_hit)
    );

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_ctr
        pmu_counter #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u_ctr (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (dec.cfg_wr && ctr_hit[k]),
            .dat_we    (dec.dat_wr && ctr_hit[k]),
            .cfg_wdata (cfg_wr_val),
            .cnt_wdata (acc_wdata[CNT_W-1:0]),
            .priv_lvl  (cur_priv),
            .evt_in    (evt_in),
            .cfg_q     (cfg_q[k]),
            .cnt_q     (cnt_q[k]),
            .wrap      (wrap_vec[k])
        );
    end

    pmu_ovf_status #(.NUM_PAIRS(NUM_PAIRS)) u_sts (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (dec.sts_wr),
        .wr_bits  (acc_wdata[FIRST_CTR +: NUM_PAIRS]),
        .set_bits (wrap_vec),
        .sts_q    (sts_q),
        .any_set  (ovf_irq)
    );

    always_comb begin
        cfg_mux = '0;
        dat_mux = '0;
        for (int k = 0; k < NUM_PAIRS; k++) begin
            if (ctr_hit[k]) begin
                cfg_mux = cfg_mux | cfg_pack(cfg_q[k]);
                dat_mux = dat_mux | XLEN'(cnt_q[k]);
            end
        end
        sts_word = XLEN'(sts_q) << FIRST_CTR;
        if (dec.rd_zero) begin
            rd_next = '0;
        end else if (req.space == SPACE_DAT) begin
            rd_next = dat_mux;
        end else if (dec.rd_sts) begin
            rd_next = sts_word;
        end else begin
            rd_next = cfg_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            priv_fault <= 1'b0;
        end else begin
            rd_valid   <= dec.rd_go;
            rd_data    <= dec.rd_go ? rd_next : '0;
            priv_fault <= dec.fault;
        end
    end

endmodule

// File: rtl/pmu_regfile_chk.sv
module pmu_regfile_chk #(
    parameter int NUM_PAIRS = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic        acc_write,
    input logic        acc_space,
    input logic [7:0]  acc_idx,
    input logic [1:0]  cur_priv,
    input logic        secure_rd,
    input logic        rd_valid,
    input logic [63:0] rd_data,
    input logic        priv_fault,
    input logic        ovf_irq
);
    localparam int LAST_CTR = 4 + NUM_PAIRS - 1;

    logic dat_unimpl;
    logic sts_wr;

    always_comb begin
        dat_unimpl = (int'(acc_idx) < 4) || (int'(acc_idx) > LAST_CTR);
        sts_wr     = acc_valid && acc_write && !acc_space && (acc_idx == 8'd0);
    end

    AST_FAULT_UNPRIV: assert property (@(posedge clk) disable iff (rst)
        acc_valid && (cur_priv != 2'd0) && (acc_write || !acc_space)
        |=> priv_fault && !rd_valid) else $error("fault missing"); // R3

    AST_NO_FAULT_PRIV0: assert property (@(posedge clk) disable iff (rst)
        acc_valid && (cur_priv == 2'd0) |=> !priv_fault) else $error("spurious fault"); // R3

    AST_SECURE_ZERO: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_write && acc_space && (cur_priv != 2'd0) && secure_rd
        |=> rd_valid && (rd_data == 64'd0)) else $error("secure read leak"); // R4

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_write && acc_space && (cur_priv == 2'd0) && dat_unimpl
        |=> rd_valid && (rd_data == 64'd0)) else $error("unimplemented read nonzero"); // R1

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_irq && !sts_wr |=> ovf_irq) else $error("overflow not sticky"); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !rd_valid && !priv_fault && (rd_data == 64'd0)) else $error("output without request"); // R11

    AST_FAULT_XOR_READ: assert property (@(posedge clk) disable iff (rst)
        !(priv_fault && rd_valid)) else $error("fault with data"); // R3

endmodule

bind pmu_regfile pmu_regfile_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_space  (acc_space),
    .acc_idx    (acc_idx),
    .cur_priv   (cur_priv),
    .secure_rd  (secure_rd),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .priv_fault (priv_fault),
    .ovf_irq    (ovf_irq)
);

// File: tb/pmu_regfile_bench.sv
module pmu_regfile_bench;

    localparam int NUM_PAIRS = 4;
    localparam int CNT_W     = 16;
    localparam int NUM_EVT   = 8;
    localparam logic CFG = 1'b0;
    localparam logic DAT = 1'b1;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               acc_valid = 1'b0;
    logic               acc_write = 1'b0;
    logic               acc_space = 1'b0;
    logic [7:0]         acc_idx = '0;
    logic [63:0]        acc_wdata = '0;
    logic [1:0]         cur_priv = '0;
    logic               secure_rd = 1'b0;
    logic [NUM_EVT-1:0] evt_in = '0;
    logic               rd_valid;
    logic [63:0]        rd_data;
    logic               priv_fault;
    logic               ovf_irq;

    int   n_tests = 0;
    int   n_fail  = 0;
    logic done    = 1'b0;

    logic        got_v;
    logic [63:0] got_d;
    logic        got_f;

    always #5 clk = ~clk;

    pmu_regfile #(.NUM_PAIRS(NUM_PAIRS), .CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u_pmu_regfile (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_space(acc_space), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
        .cur_priv(cur_priv), .secure_rd(secure_rd), .evt_in(evt_in),
        .rd_valid(rd_valid), .rd_data(rd_data), .priv_fault(priv_fault),
        .ovf_irq(ovf_irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_acc(input logic wr, input logic sp, input logic [7:0] idx,
                          input logic [63:0] wd, input logic [1:0] pr, input logic sec);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_space = sp; acc_idx = idx;
        acc_wdata = wd; cur_priv = pr; secure_rd = sec;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0; cur_priv = '0; secure_rd = 1'b0;
        got_v = rd_valid; got_d = rd_data; got_f = priv_fault;
    endtask

    task automatic rd0(input logic sp, input logic [7:0] idx);
        do_acc(1'b0, sp, idx, '0, 2'd0, 1'b0);
    endtask

    task automatic wr0(input logic sp, input logic [7:0] idx, input logic [63:0] wd);
        do_acc(1'b1, sp, idx, wd, 2'd0, 1'b0);
    endtask

    task automatic pulse_evt(input logic [NUM_EVT-1:0] ev, input logic [1:0] pr, input int n);
        @(negedge clk);
        evt_in = ev; cur_priv = pr;
        repeat (n) @(negedge clk);
        evt_in = '0; cur_priv = '0;
    endtask

    task automatic t_reset_timing();
        check("R11 rd_valid after reset", {63'd0, rd_valid}, 64'd0);
        check("R11 fault after reset", {63'd0, priv_fault}, 64'd0);
        check("R9 ovf_irq after reset", {63'd0, ovf_irq}, 64'd0);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_space = DAT; acc_idx = 8'd4;
        #1 check("R11 no data in request cycle", {63'd0, rd_valid}, 64'd0);
        @(negedge clk);
        acc_valid = 1'b0;
        check("R11 data one cycle later", {63'd0, rd_valid}, 64'd1);
        check("R11 counter reset value", rd_data, 64'd0);
        @(negedge clk);
        check("R11 valid drops after one cycle", {63'd0, rd_valid}, 64'd0);
    endtask

    task automatic t_unimpl();
        wr0(DAT, 8'd4, 64'h55);
        wr0(DAT, 8'd5, 64'h66);
        foreach (got_d[i]) begin end
        rd0(CFG, 8'd1);   check("R1 cfg slot 1", got_d, 64'd0);
        rd0(CFG, 8'd3);   check("R1 cfg slot 3", got_d, 64'd0);
        rd0(CFG, 8'd8);   check("R1 cfg slot 8", got_d, 64'd0);
        rd0(CFG, 8'd255); check("R1 cfg slot 255", got_d, 64'd0);
        rd0(DAT, 8'd0);   check("R1 data slot 0", got_d, 64'd0);
        rd0(DAT, 8'd3);   check("R1 data slot 3", got_d, 64'd0);
        check("R1 valid on unimplemented", {63'd0, got_v}, 64'd1);
        rd0(DAT, 8'd8);   check("R1 data slot 8", got_d, 64'd0);
        rd0(DAT, 8'd255); check("R1 data slot 255", got_d, 64'd0);
        // R2 writes to unimplemented slots
        wr0(DAT, 8'd8, 64'hAAAA);
        wr0(DAT, 8'd3, 64'hBBBB);
        wr0(CFG, 8'd2, 64'hFFFF);
        wr0(CFG, 8'd200, 64'hFFFF);
        rd0(DAT, 8'd4); check("R2 data4 untouched", got_d, 64'h55);
        rd0(DAT, 8'd5); check("R2 data5 untouched", got_d, 64'h66);
        rd0(DAT, 8'd7); check("R2 data7 untouched", got_d, 64'd0);
        rd0(CFG, 8'd4); check("R2 cfg4 untouched", got_d, 64'd0);
        rd0(CFG, 8'd2); check("R2 cfg2 still zero", got_d, 64'd0);
        rd0(CFG, 8'd0); check("R2 status untouched", got_d, 64'd0);
    endtask

    task automatic t_cfg_layout();
        wr0(CFG, 8'd5, 64'hFFFF_FFFF_FFFF_FFFF);
        rd0(CFG, 8'd5); check("R5 cfg field mask", got_d, 64'hFF0F);
        wr0(CFG, 8'd7, 64'h1234_5678_0000_0A05);
        rd0(CFG, 8'd7); check("R5 cfg7 fields", got_d, 64'h0A05);
        rd0(CFG, 8'd6); check("R5 cfg6 independent", got_d, 64'd0);
        wr0(CFG, 8'd5, 64'd0);
        wr0(CFG, 8'd7, 64'd0);
    endtask

    task automatic t_fault();
        do_acc(1'b1, DAT, 8'd4, 64'd77, 2'd2, 1'b0);
        check("R3 write at level 2 faults", {63'd0, got_f}, 64'd1);
        check("R3 write fault no data", {63'd0, got_v}, 64'd0);
        rd0(DAT, 8'd4); check("R3 faulted write no effect", got_d, 64'h55);
        do_acc(1'b0, CFG, 8'd4, '0, 2'd1, 1'b0);
        check("R3 cfg read at level 1 faults", {63'd0, got_f}, 64'd1);
        check("R3 cfg read fault no data", {63'd0, got_v}, 64'd0);
        do_acc(1'b1, CFG, 8'd200, 64'hF, 2'd3, 1'b0);
        check("R3 unimplemented write faults", {63'd0, got_f}, 64'd1);
        do_acc(1'b1, CFG, 8'd4, 64'h010F, 2'd1, 1'b0);
        check("R3 cfg write at level 1 faults", {63'd0, got_f}, 64'd1);
        rd0(CFG, 8'd4); check("R3 cfg unchanged", got_d, 64'd0);
        check("R3 level 0 read no fault", {63'd0, got_f}, 64'd0);
        @(negedge clk);
        check("R3 fault is one pulse", {63'd0, priv_fault}, 64'd0);
    endtask

    task automatic t_secure();
        do_acc(1'b0, DAT, 8'd4, '0, 2'd3, 1'b1);
        check("R4 secure read valid", {63'd0, got_v}, 64'd1);
        check("R4 secure read zero", got_d, 64'd0);
        check("R4 secure read no fault", {63'd0, got_f}, 64'd0);
        do_acc(1'b0, DAT, 8'd4, '0, 2'd1, 1'b0);
        check("R4 open read returns value", got_d, 64'h55);
        do_acc(1'b0, DAT, 8'd5, '0, 2'd0, 1'b1);
        check("R4 level0 ignores secure bit", got_d, 64'h66);
    endtask

    task automatic t_zext();
        wr0(DAT, 8'd6, 64'hDEAD_BEEF_CAFE_1234);
        rd0(DAT, 8'd6); check("R7 low bits loaded, zero-extended", got_d, 64'h1234);
        wr0(DAT, 8'd6, 64'hFFFF);
        rd0(DAT, 8'd6); check("R7 full-width value", got_d, 64'hFFFF);
        wr0(DAT, 8'd6, 64'd0);
    endtask

    task automatic t_count();
        wr0(CFG, 8'd4, 64'h0201);
        wr0(DAT, 8'd4, 64'd0);
        pulse_evt(8'h04, 2'd0, 5);
        rd0(DAT, 8'd4); check("R6 counts at enabled level", got_d, 64'd5);
        pulse_evt(8'h04, 2'd2, 3);
        rd0(DAT, 8'd4); check("R6 masked level ignored", got_d, 64'd5);
        pulse_evt(8'hFB, 2'd0, 3);
        rd0(DAT, 8'd4); check("R6 other events ignored", got_d, 64'd5);
        wr0(CFG, 8'd4, 64'h0204);
        pulse_evt(8'h04, 2'd2, 4);
        rd0(DAT, 8'd4); check("R6 level 2 mask bit", got_d, 64'd9);
        wr0(CFG, 8'd4, 64'h090F);
        pulse_evt(8'hFF, 2'd0, 3);
        rd0(DAT, 8'd4); check("R6 out-of-range select", got_d, 64'd9);
        rd0(DAT, 8'd5); check("R6 unconfigured counter idle", got_d, 64'h66);
    endtask

    task automatic t_wprio();
        wr0(CFG, 8'd4, 64'h020F);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_space = DAT; acc_idx = 8'd4;
        acc_wdata = 64'd100; evt_in = 8'h04;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; evt_in = '0;
        rd0(DAT, 8'd4); check("R10 write wins over event", got_d, 64'd100);
        pulse_evt(8'h04, 2'd0, 1);
        rd0(DAT, 8'd4); check("R10 counting resumes", got_d, 64'd101);
    endtask

    task automatic t_ovf();
        wr0(DAT, 8'd5, 64'hFFFE);
        wr0(CFG, 8'd5, 64'h000F);
        pulse_evt(8'h01, 2'd0, 1);
        check("R8 no overflow before wrap", {63'd0, ovf_irq}, 64'd0);
        rd0(DAT, 8'd5); check("R8 counter at all ones", got_d, 64'hFFFF);
        pulse_evt(8'h01, 2'd3, 1);
        check("R8 ovf_irq after wrap", {63'd0, ovf_irq}, 64'd1);
        rd0(DAT, 8'd5); check("R8 counter wrapped", got_d, 64'd0);
        rd0(CFG, 8'd0); check("R8 status bit 5", got_d, 64'h20);
        pulse_evt(8'h01, 2'd0, 3);
        check("R9 ovf_irq sticky", {63'd0, ovf_irq}, 64'd1);
        rd0(CFG, 8'd0); check("R9 status sticky", got_d, 64'h20);
        wr0(CFG, 8'd0, 64'd0);
        check("R9 clear drops ovf_irq", {63'd0, ovf_irq}, 64'd0);
        rd0(CFG, 8'd0); check("R9 status cleared", got_d, 64'd0);
        wr0(DAT, 8'd5, 64'hFFFF);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_space = CFG; acc_idx = 8'd0;
        acc_wdata = 64'd0; evt_in = 8'h01;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; evt_in = '0;
        check("R9 same-cycle overflow beats clear", {63'd0, ovf_irq}, 64'd1);
        rd0(CFG, 8'd0); check("R9 status after collision", got_d, 64'h20);
        do_acc(1'b1, CFG, 8'd0, 64'd0, 2'd1, 1'b0);
        check("R9 unprivileged clear ignored", {63'd0, ovf_irq}, 64'd1);
        wr0(CFG, 8'd0, 64'h80);
        rd0(CFG, 8'd0); check("R9 write loads status bits", got_d, 64'h80);
        check("R9 ovf_irq follows status", {63'd0, ovf_irq}, 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_timing();
        t_unimpl();
        t_cfg_layout();
        t_fault();
        t_secure();
        t_zext();
        t_count();
        t_wprio();
        t_ovf();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule